// File: doc/BRIEF.md
# Zero-Operand Stack Execute Unit

This block is the execute stage of an 18-bit stack processor. It holds four working registers: the top data item T, the item under it S, the top of the return stack R and an address register A. Each accepted step carries out one 5-bit opcode. The opcode set covers branches and calls, memory fetches and stores, unary and binary arithmetic, a multiply step, and transfers between the registers. The deeper parts of both stacks live outside the block. The unit drives their push and pop strobes and push data, and it takes their current top entry back as an input.

Opcodes arrive on a valid/ready stream. An opcode moves into execution on any cycle in which `op_valid` and `op_ready` are both high. The upstream side keeps `op_code`, `op_lit` and `op_pc_next` stable while `op_valid` is high and `op_ready` is low. `op_ready` drops only while a memory opcode is presented and the memory holds `mem_ready` low. During that wait the read or write strobe stays asserted and the address stays steady. Read data is combinational and is taken in the cycle in which `mem_ready` is high. Branch outcome, stack strobes and state updates happen only in the cycle the opcode is accepted.

Top module: `sm_exec_unit`

## Requirements
- R1: When synchronous reset `rst` is high, T, S, R and A all return to zero.
- R2: An opcode executes only when `op_valid` and `op_ready` are both high. `op_ready` is low only while a memory opcode is valid and `mem_ready` is low. During such a wait the registers keep their values and the memory strobe stays asserted.
- R3: Opcode 0x00 (jump) and 0x02 (call) always branch to `op_lit`. A call pushes the old R to the return stack and loads R with `op_pc_next`. Opcode 0x06 (return) branches to R and loads R from `rs_under` with a return-stack pop.
- R4: Opcode 0x01 branches to `op_lit` when all 18 bits of T are zero. Opcode 0x03 branches when T bit 17 is one. Neither opcode changes T, S or the data stack.
- R5: Fetches push the data stack. 0x08 reads address R, 0x09 and 0x0B read address A, and 0x0A pushes `op_lit` without any memory read.
- R6: Stores write T to memory and then pop the data stack. 0x0C writes to address R, and 0x0D and 0x0F write to address A. `mem_rd` and `mem_wr` are never high together.
- R7: Opcodes 0x09 and 0x0D add one to A after the access, wrapping from 0x3FFFF to 0.
- R8: 0x10 inverts every bit of T. 0x11 shifts T left with a zero fill. 0x12 shifts T right with bit 17 kept.
- R9: 0x13 (multiply step) replaces T with T+S modulo 2^18 when T bit 0 is one, and otherwise leaves T as it is. S and the data stack are left unchanged.
- R10: 0x14 (XOR), 0x15 (AND) and 0x17 (add modulo 2^18) combine S with T into T, load S from `ds_under` and pop the data stack.
- R11: 0x18 pushes R onto the data stack and pops the return stack into R. 0x19 pushes A, 0x1A pushes a copy of T, and 0x1B pushes a copy of S. 0x1C moves T into R with a return-stack push. 0x1D moves T into A. 0x1F discards T. The last three pop the data stack.
- R12: Opcodes 0x04, 0x05, 0x07, 0x0E, 0x16 and 0x1E change no register, raise no strobe and take no branch.
- R13: A data-stack push asserts `ds_push` with the old S on `ds_push_data` and moves T into S. A pop asserts `ds_pop` and loads S from `ds_under`. Push and pop are never high together, on either stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Opcode on `op_code` is presented |
| op_ready | output | 1 | Unit accepts the presented opcode this cycle |
| op_code | input | 5 | Opcode |
| op_lit | input | 18 | Literal value or branch destination |
| op_pc_next | input | 18 | Return address saved by a call |
| mem_addr | output | 18 | Memory word address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 18 | Write data (T) |
| mem_rdata | input | 18 | Combinational read data |
| mem_ready | input | 1 | Memory completes the access this cycle |
| ds_push | output | 1 | Data-stack push |
| ds_pop | output | 1 | Data-stack pop |
| ds_push_data | output | 18 | Value pushed to the data stack (old S) |
| ds_under | input | 18 | Current top entry of the external data stack |
| rs_push | output | 1 | Return-stack push |
| rs_pop | output | 1 | Return-stack pop |
| rs_push_data | output | 18 | Value pushed to the return stack (old R) |
| rs_under | input | 18 | Current top entry of the external return stack |
| br_taken | output | 1 | Branch taken by the accepted opcode |
| br_target | output | 18 | Branch destination |
| t_out | output | 18 | T register |
| s_out | output | 18 | S register |
| r_out | output | 18 | R register |
| a_out | output | 18 | A register |

## Verification
The hardest case to reach from the ports is a memory fetch held under back-pressure. It needs an A value that was built up earlier by a literal and a move into A, and the registers must stay frozen for several cycles while the read strobe stays high. The stimulus prepares A through the opcode stream and then holds `mem_ready` low for a set number of cycles. During the wait it checks that `op_ready` is low and that T and A do not move. A second hard case is the wrap of A from 0x3FFFF to 0 on an auto-increment. It is reached by loading 0x3FFFF as a literal, moving it into A and issuing opcode 0x09.

// File: rtl/sm_exec_pkg.sv
package sm_exec_pkg;

  localparam int unsigned OPW = 5;

  localparam logic [OPW-1:0] OP_JMP   = 5'h00;
  localparam logic [OPW-1:0] OP_IFZ   = 5'h01;
  localparam logic [OPW-1:0] OP_CALL  = 5'h02;
  localparam logic [OPW-1:0] OP_IFN   = 5'h03;
  localparam logic [OPW-1:0] OP_RET   = 5'h06;
  localparam logic [OPW-1:0] OP_LDR   = 5'h08;
  localparam logic [OPW-1:0] OP_LDAI  = 5'h09;
  localparam logic [OPW-1:0] OP_LIT   = 5'h0A;
  localparam logic [OPW-1:0] OP_LDA   = 5'h0B;
  localparam logic [OPW-1:0] OP_STR   = 5'h0C;
  localparam logic [OPW-1:0] OP_STAI  = 5'h0D;
  localparam logic [OPW-1:0] OP_STA   = 5'h0F;
  localparam logic [OPW-1:0] OP_INV   = 5'h10;
  localparam logic [OPW-1:0] OP_SHL   = 5'h11;
  localparam logic [OPW-1:0] OP_SHR   = 5'h12;
  localparam logic [OPW-1:0] OP_MSTEP = 5'h13;
  localparam logic [OPW-1:0] OP_XOR   = 5'h14;
  localparam logic [OPW-1:0] OP_AND   = 5'h15;
  localparam logic [OPW-1:0] OP_ADD   = 5'h17;
  localparam logic [OPW-1:0] OP_RTOD  = 5'h18;
  localparam logic [OPW-1:0] OP_ATOD  = 5'h19;
  localparam logic [OPW-1:0] OP_DUP   = 5'h1A;
  localparam logic [OPW-1:0] OP_OVER  = 5'h1B;
  localparam logic [OPW-1:0] OP_TTOR  = 5'h1C;
  localparam logic [OPW-1:0] OP_TTOA  = 5'h1D;
  localparam logic [OPW-1:0] OP_IDLE  = 5'h1E;
  localparam logic [OPW-1:0] OP_DROP  = 5'h1F;

  typedef enum logic [2:0] {
    TS_KEEP, TS_ALU, TS_MEM, TS_LIT, TS_RREG, TS_AREG, TS_SREG
  } tsrc_e;

  typedef enum logic [1:0] {STK_NONE, STK_PUSH, STK_POP} stk_e;

  typedef enum logic [1:0] {RN_KEEP, RN_FROM_T, RN_FROM_PC} rnew_e;

  typedef enum logic [2:0] {BR_NONE, BR_ALWAYS, BR_ZERO, BR_NEG, BR_RET} brk_e;

  typedef enum logic [2:0] {
    ALU_INV, ALU_SHL, ALU_SHR, ALU_MSTEP, ALU_XOR, ALU_AND, ALU_ADD
  } aluop_e;

  typedef struct packed {
    tsrc_e  t_src;
    stk_e   ds_act;
    stk_e   rs_act;
    rnew_e  r_new;
    brk_e   br;
    aluop_e alu;
    logic   addr_r;
    logic   mem_rd;
    logic   mem_wr;
    logic   a_inc;
    logic   a_load;
  } ctrl_t;

endpackage

// File: rtl/sm_exec_decode.sv
module sm_exec_decode
  import sm_exec_pkg::*;
(
  input  logic [OPW-1:0] op,
  output ctrl_t          ctl
);

  always_comb begin
    ctl.t_src  = TS_KEEP;
    ctl.ds_act = STK_NONE;
    ctl.rs_act = STK_NONE;
    ctl.r_new  = RN_KEEP;
    ctl.br     = BR_NONE;
    ctl.alu    = ALU_ADD;
    ctl.addr_r = 1'b0;
    ctl.mem_rd = 1'b0;
    ctl.mem_wr = 1'b0;
    ctl.a_inc  = 1'b0;
    ctl.a_load = 1'b0;
    case (op)
      OP_JMP:  ctl.br = BR_ALWAYS;
      OP_IFZ:  ctl.br = BR_ZERO;
      OP_IFN:  ctl.br = BR_NEG;
      OP_CALL: begin
        ctl.br     = BR_ALWAYS;
        ctl.rs_act = STK_PUSH;
        ctl.r_new  = RN_FROM_PC;
      end
      OP_RET: begin
        ctl.br     = BR_RET;
        ctl.rs_act = STK_POP;
      end
      OP_LDR: begin
        ctl.mem_rd = 1'b1;
        ctl.addr_r = 1'b1;
        ctl.t_src  = TS_MEM;
        ctl.ds_act = STK_PUSH;
      end
      OP_LDAI: begin
        ctl.mem_rd = 1'b1;
        ctl.a_inc  = 1'b1;
        ctl.t_src  = TS_MEM;
        ctl.ds_act = STK_PUSH;
      end
      OP_LDA: begin
        ctl.mem_rd = 1'b1;
        ctl.t_src  = TS_MEM;
        ctl.ds_act = STK_PUSH;
      end
      OP_LIT: begin
        ctl.t_src  = TS_LIT;
        ctl.ds_act = STK_PUSH;
      end
      OP_STR: begin
        ctl.mem_wr = 1'b1;
        ctl.addr_r = 1'b1;
        ctl.t_src  = TS_SREG;
        ctl.ds_act = STK_POP;
      end
      OP_STAI: begin
        ctl.mem_wr = 1'b1;
        ctl.a_inc  = 1'b1;
        ctl.t_src  = TS_SREG;
        ctl.ds_act = STK_POP;
      end
      OP_STA: begin
        ctl.mem_wr = 1'b1;
        ctl.t_src  = TS_SREG;
        ctl.ds_act = STK_POP;
      end
      OP_INV: begin
        ctl.t_src = TS_ALU;
        ctl.alu   = ALU_INV;
      end
      OP_SHL: begin
        ctl.t_src = TS_ALU;
        ctl.alu   = ALU_SHL;
      end
      OP_SHR: begin
        ctl.t_src = TS_ALU;
        ctl.alu   = ALU_SHR;
      end
      OP_MSTEP: begin
        ctl.t_src = TS_ALU;
        ctl.alu   = ALU_MSTEP;
      end
      OP_XOR: begin
        ctl.t_src  = TS_ALU;
        ctl.alu    = ALU_XOR;
        ctl.ds_act = STK_POP;
      end
      OP_AND: begin
        ctl.t_src  = TS_ALU;
        ctl.alu    = ALU_AND;
        ctl.ds_act = STK_POP;
      end
      OP_ADD: begin
        ctl.t_src  = TS_ALU;
        ctl.alu    = ALU_ADD;
        ctl.ds_act = STK_POP;
      end
      OP_RTOD: begin
        ctl.t_src  = TS_RREG;
        ctl.ds_act = STK_PUSH;
        ctl.rs_act = STK_POP;
      end
      OP_ATOD: begin
        ctl.t_src  = TS_AREG;
        ctl.ds_act = STK_PUSH;
      end
      OP_DUP: begin
        ctl.t_src  = TS_KEEP;
        ctl.ds_act = STK_PUSH;
      end
      OP_OVER: begin
        ctl.t_src  = TS_SREG;
        ctl.ds_act = STK_PUSH;
      end
      OP_TTOR: begin
        ctl.rs_act = STK_PUSH;
        ctl.r_new  = RN_FROM_T;
        ctl.t_src  = TS_SREG;
        ctl.ds_act = STK_POP;
      end
      OP_TTOA: begin
        ctl.a_load = 1'b1;
        ctl.t_src  = TS_SREG;
        ctl.ds_act = STK_POP;
      end
      OP_DROP: begin
        ctl.t_src  = TS_SREG;
        ctl.ds_act = STK_POP;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sm_exec_alu.sv
module sm_exec_alu
  import sm_exec_pkg::*;
#(
  parameter int unsigned DW = 18
) (
  input  aluop_e        fn,
  input  logic [DW-1:0] t_in,
  input  logic [DW-1:0] s_in,
  output logic [DW-1:0] y
);

  logic [DW-1:0] sum;

  assign sum = t_in + s_in;

  always_comb begin
    case (fn)
      ALU_INV:   y = ~t_in;
      ALU_SHL:   y = {t_in[DW-2:0], 1'b0};
      ALU_SHR:   y = {t_in[DW-1], t_in[DW-1:1]};
      ALU_MSTEP: y = t_in[0] ? sum : t_in;
      ALU_XOR:   y = t_in ^ s_in;
      ALU_AND:   y = t_in & s_in;
      ALU_ADD:   y = sum;
      default:   y = t_in;
    endcase
  end

endmodule

// File: rtl/sm_exec_branch.sv
module sm_exec_branch
  import sm_exec_pkg::*;
#(
  parameter int unsigned DW = 18
) (
  input  brk_e          kind,
  input  logic [DW-1:0] t_in,
  input  logic [DW-1:0] r_in,
  input  logic [DW-1:0] lit,
  output logic          take,
  output logic [DW-1:0] target
);

  always_comb begin
    case (kind)
      BR_ALWAYS: take = 1'b1;
      BR_ZERO:   take = (t_in == '0);
      BR_NEG:    take = t_in[DW-1];
      BR_RET:    take = 1'b1;
      default:   take = 1'b0;
    endcase
    target = (kind == BR_RET) ? r_in : lit;
  end

endmodule

// File: rtl/sm_exec_unit.sv
module sm_exec_unit
  import sm_exec_pkg::*;
#(
  parameter int unsigned DW = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  output logic           op_ready,
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  op_lit,
  input  logic [DW-1:0]  op_pc_next,
  output logic [DW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ready,
  output logic           ds_push,
  output logic           ds_pop,
  output logic [DW-1:0]  ds_push_data,
  input  logic [DW-1:0]  ds_under,
  output logic           rs_push,
  output logic           rs_pop,
  output logic [DW-1:0]  rs_push_data,
  input  logic [DW-1:0]  rs_under,
  output logic           br_taken,
  output logic [DW-1:0]  br_target,
  output logic [DW-1:0]  t_out,
  output logic [DW-1:0]  s_out,
  output logic [DW-1:0]  r_out,
  output logic [DW-1:0]  a_out
);

  localparam logic [DW-1:0] ONE = DW'(1);

  ctrl_t         ctl;
  logic [DW-1:0] t_q, s_q, r_q, a_q;
  logic [DW-1:0] t_nx, s_nx, r_nx, a_nx;
  logic [DW-1:0] alu_y;
  logic          take;
  logic          is_mem;
  logic          fire;

  sm_exec_decode u_dec (
    .op  (op_code),
    .ctl (ctl)
  );

  sm_exec_alu #(.DW(DW)) u_alu (
    .fn   (ctl.alu),
    .t_in (t_q),
    .s_in (s_q),
    .y    (alu_y)
  );

  sm_exec_branch #(.DW(DW)) u_br (
    .kind   (ctl.br),
    .t_in   (t_q),
    .r_in   (r_q),
    .lit    (op_lit),
    .take   (take),
    .target (br_target)
  );

  assign is_mem    = ctl.mem_rd | ctl.mem_wr;
  assign op_ready  = !(op_valid && is_mem) || mem_ready;
  assign fire      = op_valid && op_ready;

  assign mem_rd    = op_valid && ctl.mem_rd;
  assign mem_wr    = op_valid && ctl.mem_wr;
  assign mem_addr  = ctl.addr_r ? r_q : a_q;
  assign mem_wdata = t_q;

  assign ds_push      = fire && (ctl.ds_act == STK_PUSH);
  assign ds_pop       = fire && (ctl.ds_act == STK_POP);
  assign ds_push_data = s_q;
  assign rs_push      = fire && (ctl.rs_act == STK_PUSH);
  assign rs_pop       = fire && (ctl.rs_act == STK_POP);
  assign rs_push_data = r_q;

  assign br_taken = fire && take;

  always_comb begin
    case (ctl.t_src)
      TS_ALU:  t_nx = alu_y;
      TS_MEM:  t_nx = mem_rdata;
      TS_LIT:  t_nx = op_lit;
      TS_RREG: t_nx = r_q;
      TS_AREG: t_nx = a_q;
      TS_SREG: t_nx = s_q;
      default: t_nx = t_q;
    endcase

    case (ctl.ds_act)
      STK_PUSH: s_nx = t_q;
      STK_POP:  s_nx = ds_under;
      default:  s_nx = s_q;
    endcase

    case (ctl.rs_act)
      STK_PUSH: r_nx = (ctl.r_new == RN_FROM_PC) ? op_pc_next : t_q;
      STK_POP:  r_nx = rs_under;
      default:  r_nx = r_q;
    endcase

    if (ctl.a_load)     a_nx = t_q;
    else if (ctl.a_inc) a_nx = a_q + ONE;
    else                a_nx = a_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q <= '0;
      s_q <= '0;
      r_q <= '0;
      a_q <= '0;
    end else if (fire) begin
      t_q <= t_nx;
      s_q <= s_nx;
      r_q <= r_nx;
      a_q <= a_nx;
    end
  end

  assign t_out = t_q;
  assign s_out = s_q;
  assign r_out = r_q;
  assign a_out = a_q;

endmodule

// File: rtl/sm_exec_chk.sv
module sm_exec_chk #(
  parameter int unsigned DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic          op_ready,
  input logic [4:0]    op_code,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          ds_push,
  input logic          ds_pop,
  input logic          rs_push,
  input logic          rs_pop,
  input logic          br_taken,
  input logic [DW-1:0] t_out,
  input logic [DW-1:0] s_out,
  input logic [DW-1:0] r_out,
  input logic [DW-1:0] a_out
);

  logic fire;
  logic undef_op;
  assign fire = op_valid && op_ready;
  assign undef_op = (op_code == 5'h04) || (op_code == 5'h05) || (op_code == 5'h07) ||
                    (op_code == 5'h0E) || (op_code == 5'h16) || (op_code == 5'h1E);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (t_out == '0 && s_out == '0 && r_out == '0 && a_out == '0));

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_ready) |=> ($stable(t_out) && $stable(s_out) && $stable(r_out) && $stable(a_out)));

  p_ready_mem_only_r2: assert property (@(posedge clk) disable iff (rst)
    !op_ready |-> (mem_rd || mem_wr));

  p_branch_class_r3: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (op_code == 5'h00 || op_code == 5'h01 || op_code == 5'h02 ||
                  op_code == 5'h03 || op_code == 5'h06));

  p_ifzero_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && op_code == 5'h01 && t_out == '0) |-> br_taken);

  p_rdwr_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_a_step_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && op_code == 5'h09) |=> (a_out == ($past(a_out) + DW'(1))));

  p_dup_r11: assert property (@(posedge clk) disable iff (rst)
    (fire && op_code == 5'h1A) |=> (t_out == $past(t_out) && s_out == $past(t_out)));

  p_undef_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (fire && undef_op) |=> ($stable(t_out) && $stable(s_out) && $stable(r_out) && $stable(a_out)));

  p_stack_excl_r13: assert property (@(posedge clk) disable iff (rst)
    !(ds_push && ds_pop) && !(rs_push && rs_pop));

endmodule

bind sm_exec_unit sm_exec_chk #(.DW(DW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_code  (op_code),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .ds_push  (ds_push),
  .ds_pop   (ds_pop),
  .rs_push  (rs_push),
  .rs_pop   (rs_pop),
  .br_taken (br_taken),
  .t_out    (t_out),
  .s_out    (s_out),
  .r_out    (r_out),
  .a_out    (a_out)
);

// File: tb/sm_exec_unit_tb_top.sv
module sm_exec_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic          op_ready;
  logic [4:0]    op_code = 5'h1E;
  logic [DW-1:0] op_lit = '0;
  logic [DW-1:0] op_pc_next = '0;
  logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;
  logic          mem_rd, mem_wr;
  logic          mem_ready = 1'b1;
  logic          ds_push, ds_pop, rs_push, rs_pop;
  logic [DW-1:0] ds_push_data, ds_under, rs_push_data, rs_under;
  logic          br_taken;
  logic [DW-1:0] br_target, t_out, s_out, r_out, a_out;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm_exec_unit #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_lit(op_lit), .op_pc_next(op_pc_next),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .ds_push(ds_push), .ds_pop(ds_pop), .ds_push_data(ds_push_data),
    .ds_under(ds_under), .rs_push(rs_push), .rs_pop(rs_pop),
    .rs_push_data(rs_push_data), .rs_under(rs_under),
    .br_taken(br_taken), .br_target(br_target),
    .t_out(t_out), .s_out(s_out), .r_out(r_out), .a_out(a_out)
  );

  // environment: memory and external stack storage
  logic [DW-1:0] dmem [64];
  logic [DW-1:0] dstk [32];
  logic [DW-1:0] rstk [32];
  logic [4:0]    dsp = '0;
  logic [4:0]    rsp = '0;

  assign mem_rdata = dmem[mem_addr[5:0]];
  assign ds_under  = (dsp == 0) ? '0 : dstk[dsp - 5'd1];
  assign rs_under  = (rsp == 0) ? '0 : rstk[rsp - 5'd1];

  always @(posedge clk) begin
    if (mem_wr && mem_ready) dmem[mem_addr[5:0]] <= mem_wdata;
    if (ds_push) begin
      dstk[dsp] <= ds_push_data;
      dsp <= dsp + 5'd1;
    end else if (ds_pop && dsp != 0) dsp <= dsp - 5'd1;
    if (rs_push) begin
      rstk[rsp] <= rs_push_data;
      rsp <= rsp + 5'd1;
    end else if (rs_pop && rsp != 0) rsp <= rsp - 5'd1;
  end

  // reference model state
  logic [DW-1:0] mT = '0, mS = '0, mR = '0, mA = '0;
  logic [DW-1:0] mmem [64];
  logic [DW-1:0] mds [32];
  logic [DW-1:0] mrs [32];
  int mdsp = 0;
  int mrsp = 0;

  typedef struct {
    logic [DW-1:0] t, s, r, a;
    string tag;
  } exp_t;
  exp_t sbq[$];
  event ev_step;

  task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected state after each accepted opcode
  initial begin
    forever begin
      @(ev_step);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        chk(t_out == e.t, {e.tag, " T"}, t_out, e.t);
        chk(s_out == e.s, {e.tag, " S"}, s_out, e.s);
        chk(r_out == e.r, {e.tag, " R"}, r_out, e.r);
        chk(a_out == e.a, {e.tag, " A"}, a_out, e.a);
      end
    end
  end

  function automatic logic [DW-1:0] m_under();
    return (mdsp == 0) ? '0 : mds[mdsp-1];
  endfunction

  task automatic m_push(input logic [DW-1:0] v);
    mds[mdsp] = mS;
    mdsp++;
    mS = mT;
    mT = v;
  endtask

  task automatic m_pop_to_t(input logic [DW-1:0] v);
    mT = v;
    mS = m_under();
    if (mdsp > 0) mdsp--;
  endtask

  task automatic r_push(input logic [DW-1:0] v);
    mrs[mrsp] = mR;
    mrsp++;
    mR = v;
  endtask

  task automatic r_pop();
    mR = (mrsp == 0) ? '0 : mrs[mrsp-1];
    if (mrsp > 0) mrsp--;
  endtask

  // driver: presents one opcode, checks combinational outputs, queues expected state
  task automatic do_op(input logic [4:0] op, input logic [DW-1:0] lit,
                       input logic [DW-1:0] pcn, input int stall, input string tag);
    logic          e_br = 1'b0;
    logic [DW-1:0] e_tgt = lit;
    logic          e_rd = 1'b0, e_wr = 1'b0;
    logic [DW-1:0] e_addr = '0, e_wd = mT;
    logic [DW-1:0] pT = mT, pA = mA;
    logic [DW-1:0] v;
    exp_t e;
    @(negedge clk);
    op_code = op; op_lit = lit; op_pc_next = pcn; op_valid = 1'b1;
    mem_ready = (stall > 0) ? 1'b0 : 1'b1;
    case (op)
      5'h00: e_br = 1'b1;
      5'h01: e_br = (mT == '0);
      5'h02: begin e_br = 1'b1; r_push(pcn); end
      5'h03: e_br = mT[17];
      5'h06: begin e_br = 1'b1; e_tgt = mR; r_pop(); end
      5'h08: begin e_rd = 1; e_addr = mR; m_push(mmem[mR[5:0]]); end
      5'h09: begin e_rd = 1; e_addr = mA; m_push(mmem[mA[5:0]]); mA = mA + 1'b1; end
      5'h0A: m_push(lit);
      5'h0B: begin e_rd = 1; e_addr = mA; m_push(mmem[mA[5:0]]); end
      5'h0C: begin e_wr = 1; e_addr = mR; mmem[mR[5:0]] = mT; m_pop_to_t(mS); end
      5'h0D: begin e_wr = 1; e_addr = mA; mmem[mA[5:0]] = mT; m_pop_to_t(mS); mA = mA + 1'b1; end
      5'h0F: begin e_wr = 1; e_addr = mA; mmem[mA[5:0]] = mT; m_pop_to_t(mS); end
      5'h10: mT = ~mT;
      5'h11: mT = mT << 1;
      5'h12: mT = {mT[17], mT[17:1]};
      5'h13: if (mT[0]) mT = mT + mS;
      5'h14: m_pop_to_t(mT ^ mS);
      5'h15: m_pop_to_t(mT & mS);
      5'h17: m_pop_to_t(mT + mS);
      5'h18: begin v = mR; r_pop(); m_push(v); end
      5'h19: m_push(mA);
      5'h1A: m_push(mT);
      5'h1B: m_push(mS);
      5'h1C: begin r_push(mT); m_pop_to_t(mS); end
      5'h1D: begin mA = mT; m_pop_to_t(mS); end
      5'h1F: m_pop_to_t(mS);
      default: ;
    endcase
    #1;
    chk(mem_rd == e_rd, {tag, " mem_rd"}, DW'(mem_rd), DW'(e_rd));
    chk(mem_wr == e_wr, {tag, " mem_wr"}, DW'(mem_wr), DW'(e_wr));
    if (e_rd || e_wr) chk(mem_addr == e_addr, {tag, " mem_addr"}, mem_addr, e_addr);
    if (e_wr) chk(mem_wdata == e_wd, {tag, " mem_wdata"}, mem_wdata, e_wd);
    for (int k = 0; k < stall; k++) begin
      chk(op_ready == 1'b0, {tag, " R2 ready low in wait"}, DW'(op_ready), '0);
      chk(br_taken == 1'b0, {tag, " R2 no branch in wait"}, DW'(br_taken), '0);
      @(posedge clk);
      #1;
      chk(t_out == pT, {tag, " R2 T held"}, t_out, pT);
      chk(a_out == pA, {tag, " R2 A held"}, a_out, pA);
      chk(mem_rd == e_rd, {tag, " R2 strobe held"}, DW'(mem_rd), DW'(e_rd));
      @(negedge clk);
    end
    mem_ready = 1'b1;
    #1;
    chk(op_ready == 1'b1, {tag, " R2 ready"}, DW'(op_ready), DW'(1));
    chk(br_taken == e_br, {tag, " br_taken"}, DW'(br_taken), DW'(e_br));
    if (e_br) chk(br_target == e_tgt, {tag, " br_target"}, br_target, e_tgt);
    e.t = mT; e.s = mS; e.r = mR; e.a = mA; e.tag = tag;
    sbq.push_back(e);
    @(posedge clk);
    -> ev_step;
    #3;
    op_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL R2 watchdog expired act=%h exp=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      dmem[i] = DW'(i * 3 + 7);
      mmem[i] = DW'(i * 3 + 7);
    end
    for (int i = 0; i < 32; i++) begin
      dstk[i] = '0; rstk[i] = '0; mds[i] = '0; mrs[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(t_out == '0, "R1 reset T", t_out, '0);
    chk(s_out == '0, "R1 reset S", s_out, '0);
    chk(r_out == '0, "R1 reset R", r_out, '0);
    chk(a_out == '0, "R1 reset A", a_out, '0);
    chk(op_ready == 1'b1, "R1 R2 idle ready", DW'(op_ready), DW'(1));

    // literals, wrapping add, stack push/pop
    do_op(5'h0A, 18'h00005, '0, 0, "R5 R13 lit 5");
    do_op(5'h0A, 18'h3FFFF, '0, 0, "R5 lit max");
    do_op(5'h0A, 18'h00003, '0, 0, "R5 lit 3");
    do_op(5'h17, '0, '0, 0, "R10 add wrap");
    do_op(5'h1D, '0, '0, 0, "R11 T to A");
    do_op(5'h0F, '0, '0, 0, "R6 store A");
    // fetch under back-pressure
    do_op(5'h0B, '0, '0, 3, "R2 R5 fetch A stalled");
    do_op(5'h09, '0, '0, 1, "R5 R7 fetch A inc");
    do_op(5'h0D, '0, '0, 0, "R6 R7 store A inc");
    do_op(5'h0B, '0, '0, 0, "R5 read back");
    // A wrap
    do_op(5'h0A, 18'h3FFFF, '0, 0, "R5 lit for wrap");
    do_op(5'h1D, '0, '0, 0, "R11 load A max");
    do_op(5'h09, '0, '0, 0, "R7 A wraps");
    // return-stack addressed memory
    do_op(5'h0A, 18'h0000C, '0, 0, "R5 lit addr");
    do_op(5'h1C, '0, '0, 0, "R11 T to R");
    do_op(5'h08, '0, '0, 2, "R5 fetch R");
    do_op(5'h0C, '0, '0, 0, "R6 store R");
    do_op(5'h08, '0, '0, 0, "R6 read back R");
    do_op(5'h18, '0, '0, 0, "R11 R to data");
    // unary ops
    do_op(5'h0A, 18'h20001, '0, 0, "R5 lit signed");
    do_op(5'h12, '0, '0, 0, "R8 shr keeps sign");
    do_op(5'h11, '0, '0, 0, "R8 shl");
    do_op(5'h10, '0, '0, 0, "R8 invert");
    // multiply step
    do_op(5'h0A, 18'h00011, '0, 0, "R5 lit mcand");
    do_op(5'h0A, 18'h00003, '0, 0, "R5 lit odd");
    do_op(5'h13, '0, '0, 0, "R9 mstep odd adds");
    do_op(5'h13, '0, '0, 0, "R9 mstep even keeps");
    // logic
    do_op(5'h14, '0, '0, 0, "R10 xor");
    do_op(5'h0A, 18'h0F0F0, '0, 0, "R5 lit mask");
    do_op(5'h15, '0, '0, 0, "R10 and");
    // transfers
    do_op(5'h19, '0, '0, 0, "R11 A to data");
    do_op(5'h1A, '0, '0, 0, "R11 dup");
    do_op(5'h1B, '0, '0, 0, "R11 over");
    do_op(5'h1F, '0, '0, 0, "R11 drop");
    // undefined and idle opcodes
    do_op(5'h04, '0, '0, 0, "R12 undef 04");
    do_op(5'h05, '0, '0, 0, "R12 undef 05");
    do_op(5'h07, '0, '0, 0, "R12 undef 07");
    do_op(5'h0E, '0, '0, 0, "R12 undef 0E");
    do_op(5'h16, '0, '0, 0, "R12 undef 16");
    do_op(5'h1E, '0, '0, 0, "R12 idle");
    // branches
    do_op(5'h00, 18'h00100, '0, 0, "R3 jump");
    do_op(5'h02, 18'h00200, 18'h00055, 0, "R3 call");
    do_op(5'h02, 18'h00300, 18'h00077, 0, "R3 nested call");
    do_op(5'h06, '0, '0, 0, "R3 return");
    do_op(5'h06, '0, '0, 0, "R3 return outer");
    do_op(5'h0A, 18'h00000, '0, 0, "R5 lit zero");
    do_op(5'h01, 18'h00123, '0, 0, "R4 if zero taken");
    do_op(5'h03, 18'h00124, '0, 0, "R4 neg not taken");
    do_op(5'h10, '0, '0, 0, "R8 invert to ones");
    do_op(5'h01, 18'h00125, '0, 0, "R4 if nonzero not taken");
    do_op(5'h03, 18'h00126, '0, 0, "R4 neg taken");

    repeat (3) @(posedge clk);
    #1;
    chk(sbq.size() == 0, "R2 scoreboard drained", DW'(sbq.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule